// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Unit

This block is a general-purpose I/O port with interrupts on individual pin edges. A 16-bit register port controls it. Each pin has a direction bit. A pin set as an output is driven from an output data register. Every pin is brought through a synchroniser, and its current level can be read back whatever its direction.

A synchronised rising or falling transition can latch a status bit. Rising edges and falling edges each have their own enable register and their own status register. A status bit is cleared by writing 1 to it.

The block has one interrupt line. It is high while any status bit is set and its matching enable bit is also set.

Register words cross the bus byte-swapped. The upper bus byte carries register bits 7..0, and the lower bus byte carries register bits 15..8. Pad drivers and pin function muxing are left to the surrounding logic.

Top module: `gpioirq_unit`

## Requirements
- R1: After reset, every register reads 0, `pinOutEn` is 0, `pinOut` is 0 and `irq` is 0.
- R2: A 1 in bit i of the direction register (address 0) sets `pinOutEn[i]`. `pinOut` always equals the output data register (address 2).
- R3: The input register (address 1) returns the level of `pinIn`, including pins configured as outputs. A change becomes readable two clock edges after it is seen.
- R4: A rising transition on pin i sets bit i of the rising status register (address 5) if bit i of the rising enable register (address 3) is 1. The status bit is set on the third clock edge after the pin change.
- R5: A falling transition on pin i sets bit i of the falling status register (address 6) if bit i of the falling enable register (address 4) is 1.
- R6: An edge on a pin whose matching enable bit is 0 leaves the status register unchanged. An edge of the opposite polarity also leaves it unchanged.
- R7: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a write-1 clear and a new enabled edge hit the same status bit on the same clock edge, the bit ends up set.
- R9: `irq` is 1 exactly when some bit is set in both a status register and its enable register. Clearing the enable drops `irq` while the status bit stays set.
- R10: Writes and reads are byte-swapped. Bus bits 15..8 carry register bits 7..0, and bus bits 7..0 carry register bits 15..8.
- R11: Address 7 reads 0. Writes to address 7 or to the input register change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe, applied on the rising clock edge |
| regWrData | input | 16 | Write word in bus byte order |
| regRdData | output | 16 | Read word in bus byte order, combinational from regAddr |
| pinIn | input | 16 | Pin levels from the pads, asynchronous |
| pinOut | output | 16 | Output data toward the pads |
| pinOutEn | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 16 pins and a two-stage synchroniser. At these settings the byte swap exchanges two real bytes, so one written word checks both the write and the read paths, and the swapped result is also visible on `pinOut`. The bench times each pin change against the fixed three-edge path to the status registers. This lets it land a clear write on exactly the edge where a new event is latched.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;

  typedef enum logic [2:0] {
    SEL_DIR     = 3'd0,
    SEL_IN      = 3'd1,
    SEL_OUT     = 3'd2,
    SEL_RISE_EN = 3'd3,
    SEL_FALL_EN = 3'd4,
    SEL_RISE_ST = 3'd5,
    SEL_FALL_ST = 3'd6,
    SEL_NONE    = 3'd7
  } regSel_e;

  typedef struct packed {
    logic dirWr;
    logic outWr;
    logic riseEnWr;
    logic fallEnWr;
    logic riseClr;
    logic fallClr;
  } regStrobes_t;

endpackage

// File: rtl/gpioirq_ctrl.sv
module gpioirq_ctrl
  import gpioirq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regSel_e           rdSel,
  output regStrobes_t       stb
);

  always_comb begin
    rdSel = SEL_NONE;
    if (regAddr < ADDR_W'(7)) rdSel = regSel_e'(regAddr[2:0]);
  end

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      unique case (rdSel)
        SEL_DIR:     stb.dirWr    = 1'b1;
        SEL_OUT:     stb.outWr    = 1'b1;
        SEL_RISE_EN: stb.riseEnWr = 1'b1;
        SEL_FALL_EN: stb.fallEnWr = 1'b1;
        SEL_RISE_ST: stb.riseClr  = 1'b1;
        SEL_FALL_ST: stb.fallClr  = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R11

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (stb == '0)); // R11

endmodule

// File: rtl/gpioirq_datapath.sv
module gpioirq_datapath
  import gpioirq_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      stb,
  input  regSel_e          rdSel,
  input  logic [PIN_W-1:0] wrData,
  output logic [PIN_W-1:0] rdData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOutEn,
  output logic             irq
);

  localparam int HALF_W = PIN_W / 2;

  function automatic logic [PIN_W-1:0] swapHalves(input logic [PIN_W-1:0] w);
    return {w[HALF_W-1:0], w[PIN_W-1:HALF_W]};
  endfunction

  logic [PIN_W-1:0] syncChain [SYNC_STAGES];
  logic [PIN_W-1:0] syncLevel, prevLevel;
  logic [PIN_W-1:0] dirReg, outReg, riseEn, fallEn, riseStat, fallStat;
  logic [PIN_W-1:0] wrWord, riseHit, fallHit, rdWord;

  assign wrWord = swapHalves(wrData);

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '0;
    else prevLevel <= syncLevel;
  end

  assign riseHit = syncLevel & ~prevLevel & riseEn;
  assign fallHit = ~syncLevel & prevLevel & fallEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
      riseEn <= '0;
      fallEn <= '0;
    end else begin
      if (stb.dirWr)    dirReg <= wrWord;
      if (stb.outWr)    outReg <= wrWord;
      if (stb.riseEnWr) riseEn <= wrWord;
      if (stb.fallEnWr) fallEn <= wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseStat <= '0;
      fallStat <= '0;
    end else begin
      riseStat <= (riseStat & ~(stb.riseClr ? wrWord : '0)) | riseHit;
      fallStat <= (fallStat & ~(stb.fallClr ? wrWord : '0)) | fallHit;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_DIR:     rdWord = dirReg;
      SEL_IN:      rdWord = syncLevel;
      SEL_OUT:     rdWord = outReg;
      SEL_RISE_EN: rdWord = riseEn;
      SEL_FALL_EN: rdWord = fallEn;
      SEL_RISE_ST: rdWord = riseStat;
      SEL_FALL_ST: rdWord = fallStat;
      default:     rdWord = '0;
    endcase
  end

  assign rdData   = swapHalves(rdWord);
  assign pinOut   = outReg;
  assign pinOutEn = dirReg;
  assign irq      = |((riseStat & riseEn) | (fallStat & fallEn));

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(riseHit) & ~riseStat) == '0) && (($past(fallHit) & ~fallStat) == '0)); // R8

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    ((riseStat & ~$past(riseStat) & ~$past(riseEn)) == '0)); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((riseStat | fallStat) != '0)); // R9

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.dirWr) |-> $stable(dirReg)); // R11

endmodule

// File: rtl/gpioirq_unit.sv
module gpioirq_unit
  import gpioirq_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PIN_W-1:0]  regWrData,
  output logic [PIN_W-1:0]  regRdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutEn,
  output logic              irq
);

  regSel_e     rdSel;
  regStrobes_t stb;

  gpioirq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .rdSel(rdSel), .stb(stb)
  );

  gpioirq_datapath #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(regWrData),
    .rdData(regRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .irq(irq)
  );

endmodule

// File: tb/gpioirq_unit_test.sv
module gpioirq_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOutEn;
  logic        irq;

  gpioirq_unit uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t queueExp[$];
  logic  rdReq = 1'b0;
  int    checks = 0;
  int    failures = 0;
  bit    doneFlag = 0;

  function automatic logic [15:0] sw(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  always @(negedge clk) begin
    if (rdReq && queueExp.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = queueExp.pop_front();
      case (it.kind)
        0: act = regRdData;
        1: act = {15'd0, irq};
        2: act = pinOut;
        default: act = pinOutEn;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectItem(input int kind, input logic [2:0] a,
                            input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    regAddr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    queueExp.push_back(it);
    rdReq = 1'b1;
    @(negedge clk);
    #1 rdReq = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] busWord);
    @(posedge clk);
    #1;
    regAddr = a; regWrData = busWord; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic setPins(input logic [15:0] v);
    @(posedge clk);
    #1 pinIn = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) expectItem(0, 3'(a), 16'h0000, "R1 reg after reset");
    expectItem(1, 0, 16'h0000, "R1 irq after reset");
    expectItem(2, 0, 16'h0000, "R1 pinOut after reset");
    expectItem(3, 0, 16'h0000, "R1 pinOutEn after reset");

    // R2 / R10 direction, output data, byte swap
    regWrite(0, sw(16'h00FF));
    regWrite(2, 16'h1234);
    expectItem(3, 0, 16'h00FF, "R2 pinOutEn from direction");
    expectItem(2, 0, 16'h3412, "R10 write swap seen on pinOut");
    expectItem(0, 2, 16'h1234, "R10 read swap of output reg");

    // R3 input level regardless of direction
    setPins(16'hA5C3);
    expectItem(0, 1, sw(16'hA5C3), "R3 input readback");

    // R4/R5/R6 edges
    setPins(16'h0000);
    regWrite(3, sw(16'h0003));
    regWrite(4, sw(16'h0100));
    regWrite(5, sw(16'hFFFF));
    regWrite(6, sw(16'hFFFF));
    setPins(16'h0105);
    expectItem(0, 5, sw(16'h0001), "R4 rise status only enabled bit");
    expectItem(0, 6, sw(16'h0000), "R6 fall status untouched by rises");
    expectItem(1, 0, 16'h0001, "R9 irq from enabled status");
    setPins(16'h0004);
    expectItem(0, 6, sw(16'h0100), "R5 fall status");
    expectItem(0, 5, sw(16'h0001), "R6 rise status untouched by falls");

    // R7 write-1-clear
    regWrite(5, sw(16'h0002));
    expectItem(0, 5, sw(16'h0001), "R7 zero bits left set");
    regWrite(6, sw(16'h0100));
    regWrite(5, sw(16'h0001));
    expectItem(0, 6, sw(16'h0000), "R7 fall cleared");
    expectItem(0, 5, sw(16'h0000), "R7 rise cleared");
    expectItem(1, 0, 16'h0000, "R9 irq low with no status");

    // R9 masking
    setPins(16'h0006);
    expectItem(1, 0, 16'h0001, "R9 irq on bit1 rise");
    regWrite(3, sw(16'h0000));
    expectItem(1, 0, 16'h0000, "R9 irq dropped by enable");
    expectItem(0, 5, sw(16'h0002), "R9 status kept after mask");
    regWrite(3, sw(16'h0003));

    // R8 set wins over same-edge clear
    setPins(16'h0004);
    @(posedge clk);
    #1 pinIn = 16'h0006;
    @(posedge clk);
    @(posedge clk);
    #1;
    regAddr = 5; regWrData = sw(16'h0002); regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
    expectItem(0, 5, sw(16'h0002), "R8 set wins over clear");
    regWrite(5, sw(16'h0002));
    expectItem(0, 5, sw(16'h0000), "R7 later clear succeeds");

    // R11 unmapped and read-only
    regWrite(7, 16'hFFFF);
    regWrite(1, 16'hFFFF);
    expectItem(0, 7, 16'h0000, "R11 unmapped reads zero");
    expectItem(0, 0, sw(16'h00FF), "R11 direction unchanged");
    expectItem(0, 2, 16'h1234, "R11 output unchanged");
    expectItem(0, 1, sw(16'h0006), "R11 input unaffected");
    expectItem(0, 3, sw(16'h0003), "R11 rise enable unchanged");

    repeat (2) @(posedge clk);
    doneFlag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule